// File: doc/BRIEF.md
# Cell View Address Decoder

This block sits between a storage-space bus port and an array of inter-thread communication cells. Each bus request carries an address, a write flag, a size code and write data. The decoder splits the address into two parts. Address bits [6:3] select an access view. The address shifted right by seven plus a programmable grain selects a target cell. For a legal full-width access to one of the six cell views, the decoder raises a one-hot strobe toward the cells for that single cycle. It also drives the cell index, the direction and a flag that tells whether the cell is a FIFO cell or a semaphore cell.

The decoder holds one global control/status word at view 15. That word carries three sticky error flags, the 3-bit cell-spacing grain and the fixed cell count. A byte-wide or halfword-wide access never reaches a cell. It sets the bus-width error flag and returns an error response. The two other error flags are set by external event pulses, and software clears flags by writing ones to them. The response is registered and appears in the cycle after the request. Read data comes from the selected cell's read word, from the global word, or is all ones for a view that has no meaning.

FIFO cells occupy the lower indices, from 0 to NUM_FIFO-1, and semaphore cells follow them.

Top module: `cell_view_decoder`

## Requirements
- R1: For a request with req_valid=1 and a full size code (2 = word, 3 = doubleword), a view code v in 0..5 raises only bit v of cell_stb in the same cycle, and cell_we equals req_write. The view codes are 0 raw, 1 tag, 2 empty/full blocking, 3 empty/full polling, 4 P/V blocking and 5 P/V polling. At all other times cell_stb is zero.
- R2: cell_idx equals req_addr shifted right by (7 + grain), where grain is bits [10:8] of the global word.
- R3: A computed index at or above NUM_CELLS is replaced by NUM_CELLS-1.
- R4: A request with size code 0 (byte) or 1 (halfword) raises no strobe. In the next cycle it gives rsp_valid=1, rsp_err=1 and rsp_rdata=0, and it sets bit 2 of the global word.
- R5: A full-width write to view 15 clears each bit among [2:0] of the global word whose write-data bit is 1, and it loads bits [10:8] from write data. Any other request leaves the grain unchanged.
- R6: After reset the global word reads as NUM_CELLS placed at bit 16, with zero grain and zero error bits, and rsp_valid is 0.
- R7: A full-width read of a view code in 6..14 returns 0xFFFFFFFF. A write to such a view raises no strobe and leaves the global word unchanged.
- R8: A full-width read of views 0..5 returns the selected cell's cell_rdata word in the next cycle. A read of view 15 returns the global word as it stood before that cycle's updates. A write returns 0.
- R9: A pulse on err_parity_i sets bit 1 and a pulse on err_exec_i sets bit 0. These bits stay set until they are cleared, and a set in the same cycle as a clear wins.
- R10: Every request gives rsp_valid=1 exactly one cycle later, with rsp_err=0 unless R4 applies. With no request, rsp_valid is 0.
- R11: cell_fifo is 1 when cell_idx is below NUM_FIFO and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Storage-space byte address |
| req_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_wdata | input | DATA_W | Write data |
| err_parity_i | input | 1 | Event pulse that sets error bit 1 |
| err_exec_i | input | 1 | Event pulse that sets error bit 0 |
| cell_stb | output | 6 | One-hot per-view strobe to the cells |
| cell_we | output | 1 | Write direction to the cells |
| cell_idx | output | IDX_W | Target cell index after clamping |
| cell_fifo | output | 1 | Target cell is a FIFO cell |
| cell_wdata | output | DATA_W | Write data forwarded to the cells |
| cell_rdata | input | NUM_CELLS*DATA_W | Read words of all cells, cell i at bits [i*DATA_W +: DATA_W] |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Bus error response |
| rsp_rdata | output | DATA_W | Response read data |

## Verification
A grain register holding a wrong value shows up at once as a wrong cell_idx on the next request, because the decode is combinational. A stuck or lost error bit is only visible on the next read of view 15, so the bench reads that view right after every event that touches a flag. Errors in the response path show one cycle after the request, on rsp_valid, rsp_err or rsp_rdata. The bench compares strobes, index and response against its model on every clock, including a long pseudo-random mix of views, sizes and grains.

// File: rtl/cvd_pkg.sv
package cvd_pkg;
  localparam int unsigned VIEW_W      = 4;
  localparam int unsigned CELL_VIEWS  = 6;
  localparam logic [VIEW_W-1:0] VW_RAW     = 4'd0;
  localparam logic [VIEW_W-1:0] VW_TAG     = 4'd1;
  localparam logic [VIEW_W-1:0] VW_EF_WAIT = 4'd2;
  localparam logic [VIEW_W-1:0] VW_EF_POLL = 4'd3;
  localparam logic [VIEW_W-1:0] VW_PV_WAIT = 4'd4;
  localparam logic [VIEW_W-1:0] VW_PV_POLL = 4'd5;
  localparam logic [VIEW_W-1:0] VW_GLOBAL  = 4'd15;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam int unsigned GRAIN_W    = 3;
  localparam int unsigned GRAIN_LSB  = 8;
  localparam int unsigned COUNT_LSB  = 16;
  localparam int unsigned ERR_W      = 3;
  localparam int unsigned ERR_WIDTH_BIT = 2;
  localparam int unsigned MIN_SHIFT  = 7;
endpackage

// File: rtl/cvd_addr_decode.sv
module cvd_addr_decode
  import cvd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned NUM_CELLS = 32,
  parameter int unsigned IDX_W     = 5
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [GRAIN_W-1:0] grain,
  output logic [VIEW_W-1:0]  view,
  output logic [IDX_W-1:0]   idx
);
  localparam logic [ADDR_W-1:0] LAST_CELL = ADDR_W'(NUM_CELLS - 1);

  logic [3:0]        shift_amt;
  logic [ADDR_W-1:0] raw_idx;

  always_comb begin
    shift_amt = 4'(MIN_SHIFT) + {1'b0, grain};
    raw_idx   = addr >> shift_amt;
    view      = addr[6:3];
    if (raw_idx > LAST_CELL) begin
      idx = LAST_CELL[IDX_W-1:0];
    end else begin
      idx = raw_idx[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/cvd_global_reg.sv
module cvd_global_reg
  import cvd_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_CELLS = 32,
  parameter int unsigned CNT_W     = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               width_evt,
  input  logic               parity_evt,
  input  logic               exec_evt,
  input  logic               wr_en,
  input  logic [ERR_W-1:0]   wr_clear,
  input  logic [GRAIN_W-1:0] wr_grain,
  output logic [GRAIN_W-1:0] grain,
  output logic [DATA_W-1:0]  value
);
  logic [ERR_W-1:0]   err_q, err_d, err_set, err_clr;
  logic [GRAIN_W-1:0] grain_q, grain_d;
  logic               upd_en;

  always_comb begin
    err_set = {width_evt, parity_evt, exec_evt};
    err_clr = wr_en ? wr_clear : '0;
    err_d   = (err_q & ~err_clr) | err_set;
    grain_d = wr_en ? wr_grain : grain_q;
    upd_en  = wr_en | width_evt | parity_evt | exec_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= '0;
      grain_q <= '0;
    end else if (upd_en) begin
      err_q   <= err_d;
      grain_q <= grain_d;
    end
  end

  always_comb begin
    value = '0;
    value[ERR_W-1:0] = err_q;
    value[GRAIN_LSB +: GRAIN_W] = grain_q;
    value[COUNT_LSB +: CNT_W] = CNT_W'(NUM_CELLS);
  end

  assign grain = grain_q;

  AST_PARITY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q[1] && !err_clr[1]) |=> err_q[1]) else $error("parity flag lost"); // R9

  AST_WIDTH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    width_evt |=> err_q[ERR_WIDTH_BIT]) else $error("width flag not set"); // R4

  AST_GRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(grain_q)) else $error("grain moved without write"); // R5
endmodule

// File: rtl/cvd_rdata_mux.sv
module cvd_rdata_mux
  import cvd_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_CELLS = 32,
  parameter int unsigned IDX_W     = 5
) (
  input  logic [NUM_CELLS*DATA_W-1:0] cell_rdata,
  input  logic [IDX_W-1:0]            idx,
  input  logic [VIEW_W-1:0]           view,
  input  logic [DATA_W-1:0]           glob,
  input  logic                        rd_full,
  output logic [DATA_W-1:0]           rdata
);
  logic [DATA_W-1:0] words [NUM_CELLS];

  for (genvar g = 0; g < NUM_CELLS; g++) begin : g_unpack
    assign words[g] = cell_rdata[g*DATA_W +: DATA_W];
  end

  always_comb begin
    rdata = '0;
    if (rd_full) begin
      if (view < VIEW_W'(CELL_VIEWS)) begin
        rdata = words[idx];
      end else if (view == VW_GLOBAL) begin
        rdata = glob;
      end else begin
        rdata = '1;
      end
    end
  end
endmodule

// File: rtl/cell_view_decoder.sv
module cell_view_decoder
  import cvd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_CELLS = 32,
  parameter int unsigned NUM_FIFO  = 16,
  localparam int unsigned IDX_W    = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1,
  localparam int unsigned CNT_W    = $clog2(NUM_CELLS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [1:0]                  req_size,
  input  logic [DATA_W-1:0]           req_wdata,
  input  logic                        err_parity_i,
  input  logic                        err_exec_i,
  output logic [CELL_VIEWS-1:0]       cell_stb,
  output logic                        cell_we,
  output logic [IDX_W-1:0]            cell_idx,
  output logic                        cell_fifo,
  output logic [DATA_W-1:0]           cell_wdata,
  input  logic [NUM_CELLS*DATA_W-1:0] cell_rdata,
  output logic                        rsp_valid,
  output logic                        rsp_err,
  output logic [DATA_W-1:0]           rsp_rdata
);
  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [VIEW_W-1:0]  view;
  logic [GRAIN_W-1:0] grain;
  logic [DATA_W-1:0]  glob_value;
  logic               narrow, full_acc, glob_wr, rd_full;

  always_comb begin
    narrow   = (req_size == SZ_BYTE) || (req_size == SZ_HALF);
    full_acc = req_valid && !narrow;
    glob_wr  = full_acc && req_write && (view == VW_GLOBAL);
    rd_full  = full_acc && !req_write;
  end

  cvd_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_CELLS(NUM_CELLS), .IDX_W(IDX_W)
  ) u_decode (
    .addr(req_addr), .grain(grain), .view(view), .idx(cell_idx)
  );

  cvd_global_reg #(
    .DATA_W(DATA_W), .NUM_CELLS(NUM_CELLS), .CNT_W(CNT_W)
  ) u_global (
    .clk(clk), .rst_n(rst_sync),
    .width_evt(req_valid && narrow),
    .parity_evt(err_parity_i), .exec_evt(err_exec_i),
    .wr_en(glob_wr),
    .wr_clear(req_wdata[ERR_W-1:0]),
    .wr_grain(req_wdata[GRAIN_LSB +: GRAIN_W]),
    .grain(grain), .value(glob_value)
  );

  for (genvar v = 0; v < CELL_VIEWS; v++) begin : g_stb
    assign cell_stb[v] = full_acc && (view == VIEW_W'(v));
  end

  assign cell_we    = req_write;
  assign cell_wdata = req_wdata;
  assign cell_fifo  = (32'(cell_idx) < NUM_FIFO);

  logic [DATA_W-1:0] rdata_d;

  cvd_rdata_mux #(
    .DATA_W(DATA_W), .NUM_CELLS(NUM_CELLS), .IDX_W(IDX_W)
  ) u_rmux (
    .cell_rdata(cell_rdata), .idx(cell_idx), .view(view),
    .glob(glob_value), .rd_full(rd_full), .rdata(rdata_d)
  );

  logic              rsp_valid_d, rsp_err_d;

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_err_d   = req_valid && narrow;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_err   <= rsp_err_d;
      rsp_rdata <= rdata_d;
    end
  end

  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync)
    $onehot0(cell_stb)) else $error("more than one view strobe"); // R1

  AST_NARROW_QUIET: assert property (@(posedge clk) disable iff (!rst_sync)
    (req_valid && narrow) |-> (cell_stb == '0)) else $error("narrow access reached a cell"); // R4

  AST_IDX_CLAMPED: assert property (@(posedge clk) disable iff (!rst_sync)
    (|cell_stb) |-> (32'(cell_idx) < NUM_CELLS)) else $error("index beyond last cell"); // R3

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_sync)
    req_valid |=> rsp_valid) else $error("response missing"); // R10
endmodule

// File: tb/cell_view_decoder_tb.sv
module cell_view_decoder_tb;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int NCELL  = 32;
  localparam int NFIFO  = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [1:0]        req_size;
  logic [DATA_W-1:0] req_wdata;
  logic              err_parity_i, err_exec_i;
  logic [5:0]        cell_stb;
  logic              cell_we;
  logic [4:0]        cell_idx;
  logic              cell_fifo;
  logic [DATA_W-1:0] cell_wdata;
  logic [NCELL*DATA_W-1:0] cell_rdata;
  logic              rsp_valid, rsp_err;
  logic [DATA_W-1:0] rsp_rdata;

  always #10 clk = ~clk;

  cell_view_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CELLS(NCELL), .NUM_FIFO(NFIFO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .err_parity_i(err_parity_i), .err_exec_i(err_exec_i),
    .cell_stb(cell_stb), .cell_we(cell_we), .cell_idx(cell_idx), .cell_fifo(cell_fifo),
    .cell_wdata(cell_wdata), .cell_rdata(cell_rdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  int n_vec = 0;
  int n_bad = 0;

  int m_err = 0;
  int m_grain = 0;
  logic        x_rv = 1'b0, x_re = 1'b0;
  logic [31:0] x_rd = '0;
  string       x_tag = "R6";

  function automatic logic [31:0] cell_word(int i);
    return 32'hA500_0000 | 32'(i << 8) | 32'(i ^ 8'h3C);
  endfunction

  function automatic logic [31:0] glob_word();
    return 32'(NCELL << 16) | 32'(m_grain << 8) | 32'(m_err);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic w, input logic [15:0] a,
                      input logic [1:0] s, input logic [31:0] d,
                      input logic pe, input logic ee, input string tag);
    logic narrow;
    int view, idx;
    logic [5:0] xs;
    @(negedge clk);
    check({x_tag, " rsp_valid (R10)"}, 32'(rsp_valid), 32'(x_rv));
    check({x_tag, " rsp_err (R4)"}, 32'(rsp_err), 32'(x_re));
    check({x_tag, " rsp_rdata (R8)"}, rsp_rdata, x_rd);
    req_valid = v; req_write = w; req_addr = a; req_size = s; req_wdata = d;
    err_parity_i = pe; err_exec_i = ee;
    #1;
    narrow = (s < 2);
    view = int'(a[6:3]);
    idx = int'(a) >> (7 + m_grain);
    if (idx >= NCELL) idx = NCELL - 1;
    xs = (v && !narrow && view < 6) ? 6'(1 << view) : 6'd0;
    check({tag, " cell_stb R1"}, 32'(cell_stb), 32'(xs));
    if (xs != 0) begin
      check({tag, " cell_idx R2 R3"}, 32'(cell_idx), 32'(idx));
      check({tag, " cell_we R1"}, 32'(cell_we), 32'(w));
      check({tag, " cell_fifo R11"}, 32'(cell_fifo), 32'(idx < NFIFO));
    end
    x_tag = tag;
    x_rv = v;
    x_re = v && narrow;
    if (!v || narrow || w) x_rd = '0;
    else if (view < 6) x_rd = cell_word(idx);
    else if (view == 15) x_rd = glob_word();
    else x_rd = 32'hFFFF_FFFF;
    if (v && narrow) m_err = m_err | 4;
    if (v && !narrow && w && view == 15) begin
      m_err = m_err & ~int'(d[2:0]);
      m_grain = int'(d[10:8]);
    end
    m_err = m_err | (int'(pe) << 1) | int'(ee);
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    step(1'b1, 1'b0, a, 2'd2, 32'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input string tag);
    step(1'b1, 1'b1, a, 2'd2, d, 1'b0, 1'b0, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 16'h0, 2'd2, 32'h0, 1'b0, 1'b0, tag);
  endtask

  localparam logic [15:0] GADDR = 16'h0078;

  initial begin
    for (int i = 0; i < NCELL; i++) cell_rdata[i*DATA_W +: DATA_W] = cell_word(i);
    rst_n = 1'b0;
    req_valid = 0; req_write = 0; req_addr = '0; req_size = 2'd2; req_wdata = '0;
    err_parity_i = 0; err_exec_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    idle("R6 reset idle");
    rd(GADDR, "R6 reset global");
    for (int v = 0; v < 6; v++) begin
      rd(16'((3 << 7) | (v << 3)), "R1 view read");
      wr(16'((3 << 7) | (v << 3)), 32'h1234_0000 + 32'(v), "R1 view write");
    end
    rd(16'((20 << 7) | (2 << 3)), "R11 semaphore cell");
    rd(16'((9 << 7) | 3'd0), "R8 cell read");
    rd(16'((NCELL - 1) << 7), "R3 last cell exact");
    rd(16'(NCELL << 7), "R3 first beyond");
    step(1'b1, 1'b0, 16'h0010, 2'd0, 0, 0, 0, "R4 byte read");
    step(1'b1, 1'b1, 16'h0008, 2'd1, 32'hFFFF_FFFF, 0, 0, "R4 half write");
    rd(GADDR, "R4 flag visible");
    wr(GADDR, 32'h0000_0004, "R5 clear width");
    rd(GADDR, "R5 cleared");
    wr(GADDR, 32'h0000_0200, "R5 grain two");
    rd(GADDR, "R5 grain read");
    rd(16'((5 << 9) | (1 << 3)), "R2 grain stride");
    rd(16'hFF88, "R3 clamp high");
    wr(GADDR, 32'h0000_0700, "R5 grain seven");
    rd(16'h4000, "R2 grain seven idx");
    wr(GADDR, 32'h0, "R5 grain zero");
    rd(16'h0030, "R7 view six");
    rd(16'h0070, "R7 view fourteen");
    wr(16'h0048, 32'hFFFF_FFFF, "R7 write nine");
    rd(GADDR, "R7 global unchanged");
    step(1'b0, 0, 0, 2'd2, 0, 1'b1, 1'b0, "R9 parity pulse");
    step(1'b0, 0, 0, 2'd2, 0, 1'b0, 1'b1, "R9 exec pulse");
    idle("R9 idle");
    rd(GADDR, "R9 both set");
    step(1'b1, 1'b1, GADDR, 2'd3, 32'h3, 1'b1, 1'b0, "R9 set beats clear");
    rd(GADDR, "R9 after race");
    begin
      logic [31:0] lcg = 32'h1ACE_B00C;
      for (int k = 0; k < 400; k++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        step(lcg[31], lcg[30], lcg[15:0], lcg[17:16],
             {21'h0, lcg[29:27], 5'h0, lcg[2:0]}, lcg[25] & lcg[24], lcg[23] & lcg[22], "R10 random mix");
      end
    end
    idle("R10 drain");
    idle("R10 drain");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog R10: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule